// File: doc/BRIEF.md
# Write-Enable-Masked Control Register Bank with Frame Commit

This block holds a small set of 32-bit control registers behind a simple memory-mapped write and read port. Each register slot is configured at build time as either a masked slot or a plain slot. In a masked slot, the upper half of every write word is a per-bit write enable for the lower half. Software can therefore change one field with a single bus write and never has to read the register first. A plain slot replaces all 32 bits on every write, so software keeps its own copy and merges fields itself.

Writes only reach a shadow copy of each register. A separate commit register, one address past the last data slot, carries a config-done bit. Writing 1 to that bit arms a commit. On the next frame-start pulse, every shadow value is copied to the active outputs at once and the armed state clears by itself. Reads return the shadow (pending) values. The armed state can be read back and is also driven on a pin.

Top module: `hwm_reg_bank`

## Requirements
- R1: In a masked slot, write bit i+16 enables the update of stored bit i (i from 0 to 15), and stored bits whose enable is 0 keep their value. A field of width w at offset s is written by placing the value in bits [s+w-1:s] and setting bits [s+16+w-1:s+16].
- R2: A write to a masked slot whose bits [31:16] are all zero leaves that slot unchanged.
- R3: A write to a plain slot replaces all 32 stored bits with the write word.
- R4: A read of a masked slot returns 0 in bits [31:16] and the stored value in bits [15:0].
- R5: A read with `rd_en` high returns the shadow value in `rd_data` after the next clock edge. Writes do not change `active_out` until a commit.
- R6: A write to address NUM_REGS with bit 0 set arms a commit. A write there with bit 0 clear does nothing. The armed state is shown on `commit_pending` and in bit 0 of a read at address NUM_REGS, with all other bits of that read 0.
- R7: A `frame_start` pulse while a commit is armed copies every shadow slot to its field of `active_out` and clears the armed state. A `frame_start` pulse while nothing is armed changes nothing.
- R8: A config-done write in the same cycle as `frame_start` leaves the commit armed afterwards. If a commit was already armed, the copy still happens in that cycle. If none was armed, no copy happens.
- R9: A data write in the same cycle as a committing `frame_start` does not reach `active_out`. The copy takes the value from before that write, and the new value stays pending in the shadow.
- R10: A synchronous reset sets all shadow and active slots to zero, sets `rd_data` to zero and clears the armed state.
- R11: Writes to addresses above NUM_REGS change no slot and do not arm a commit. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 32 | Write word (upper half is the enable in masked slots) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Registered read data |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| active_out | output | NUM_REGS*32 | Committed register values, slot i at bits [32i+31:32i] |
| commit_pending | output | 1 | A commit is armed and waiting for a frame start |

## Verification
Two functions can land in one clock: the shadow-to-active copy fired by `frame_start`, and either a data write or a config-done write. The bench drives each of these pairs in a single cycle. It does this with a commit armed and with no commit armed. It then judges the result by comparing `active_out` against the shadow value from before the write, by reading back the new shadow value, and by checking whether `commit_pending` is left set.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = REG_W / 2;

  // Merge new data into old data under a per-bit enable held in the upper half.
  function automatic logic [REG_W-1:0] masked_merge(input logic [REG_W-1:0] old_v,
                                                     input logic [REG_W-1:0] wr_v);
    logic [HALF_W-1:0] en;
    en = wr_v[REG_W-1:HALF_W];
    return {{HALF_W{1'b0}}, (old_v[HALF_W-1:0] & ~en) | (wr_v[HALF_W-1:0] & en)};
  endfunction
endpackage

// File: rtl/rb_commit_ctrl.sv
module rb_commit_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic frame_start,
  output logic commit,
  output logic pending_q
);
  // The copy fires only when the commit was armed before this cycle.
  assign commit = pending_q & frame_start;

  always_ff @(posedge clk) begin
    if (rst) pending_q <= 1'b0;
    else     pending_q <= cfg_wr | (pending_q & ~frame_start);
  end

  a_r6_cfg_arms: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> pending_q);
  a_r7_commit_clears: assert property (@(posedge clk) disable iff (rst)
    (pending_q && frame_start && !cfg_wr) |=> !pending_q);
  a_r7_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!pending_q && !cfg_wr) |=> !pending_q);
endmodule

// File: rtl/rb_slot.sv
module rb_slot
  import rb_pkg::*;
#(
  parameter bit MASKED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             commit,
  output logic [REG_W-1:0] shadow_q,
  output logic [REG_W-1:0] active_q
);
  logic [REG_W-1:0] next_v;

  generate
    if (MASKED) begin : g_masked
      assign next_v = masked_merge(shadow_q, wdata);

      a_r2_empty_enable_keeps: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[REG_W-1:HALF_W] == '0) |=> $stable(shadow_q));
      a_r4_upper_half_zero: assert property (@(posedge clk) disable iff (rst)
        shadow_q[REG_W-1:HALF_W] == '0);
    end else begin : g_plain
      assign next_v = wdata;

      a_r3_full_replace: assert property (@(posedge clk) disable iff (rst)
        we |=> shadow_q == $past(wdata));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we)     shadow_q <= next_v;
      if (commit) active_q <= shadow_q;
    end
  end

  a_r9_copy_pre_write: assert property (@(posedge clk) disable iff (rst)
    commit |=> active_q == $past(shadow_q));
  a_r5_active_holds: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active_q));
endmodule

// File: rtl/hwm_reg_bank.sv
module hwm_reg_bank
  import rb_pkg::*;
#(
  parameter int                    NUM_REGS   = 8,
  parameter logic [NUM_REGS-1:0]   MASKED_MAP = 8'h0F,
  localparam int                   ADDR_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [REG_W-1:0]          rd_data,
  input  logic                      frame_start,
  output logic [NUM_REGS*REG_W-1:0] active_out,
  output logic                      commit_pending
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

  logic [REG_W-1:0] shadow [NUM_REGS];
  logic             commit;
  logic             cfg_wr;
  logic [REG_W-1:0] rd_mux;

  assign cfg_wr = wr_en && (wr_addr == CTRL_ADDR) && wr_data[0];

  rb_commit_ctrl u_commit (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .frame_start (frame_start),
    .commit      (commit),
    .pending_q   (commit_pending)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      logic we_i;
      assign we_i = wr_en && (wr_addr == ADDR_W'(i));
      rb_slot #(.MASKED(MASKED_MAP[i])) u_slot (
        .clk      (clk),
        .rst      (rst),
        .we       (we_i),
        .wdata    (wr_data),
        .commit   (commit),
        .shadow_q (shadow[i]),
        .active_q (active_out[i*REG_W +: REG_W])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_mux = shadow[i];
    if (rd_addr == CTRL_ADDR) rd_mux = {{(REG_W-1){1'b0}}, commit_pending};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr > CTRL_ADDR) |=> rd_data == '0);
  a_r11_unmapped_no_arm: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > CTRL_ADDR && !commit_pending) |=> !commit_pending);
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (active_out == '0 && !commit_pending && rd_data == '0));
endmodule

// File: tb/tb_hwm_reg_bank.sv
module tb_hwm_reg_bank;
  localparam int NR = 8;
  localparam int AW = $clog2(NR + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, rd_en, frame_start;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic [NR*32-1:0] active_out;
  logic          commit_pending;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hwm_reg_bank #(.NUM_REGS(NR), .MASKED_MAP(8'h0F)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_start(frame_start), .active_out(active_out),
    .commit_pending(commit_pending)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic fs);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; frame_start = fs;
    @(negedge clk);
    wr_en = 1'b0; frame_start = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic frame();
    cyc(1'b0, '0, '0, 1'b1);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  function automatic logic [31:0] act(input int i);
    return active_out[i*32 +: 32];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    check("R10 active after reset", active_out[31:0] | active_out[NR*32-1:NR*32-32], 32'h0);
    check("R10 pending after reset", {31'h0, commit_pending}, 32'h0);
    rd(AW'(4), v);
    check("R10 read after reset", v, 32'h0);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(AW'(0), 32'hFFFF_1234);
    rd(AW'(0), v);
    check("R4 masked full write", v, 32'h0000_1234);
    wr(AW'(0), 32'h00F0_ABCD);
    rd(AW'(0), v);
    check("R1 nibble enable", v, 32'h0000_12C4);
    wr(AW'(0), 32'h0000_FFFF);
    rd(AW'(0), v);
    check("R2 empty enable", v, 32'h0000_12C4);
    wr(AW'(0), 32'h0E00_0A00);   // field width 3 at offset 9, value 5
    rd(AW'(0), v);
    check("R1 field write", v, 32'h0000_1AC4);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(AW'(4), 32'hDEAD_BEEF);
    rd(AW'(4), v);
    check("R3 plain write", v, 32'hDEAD_BEEF);
    wr(AW'(4), 32'h0000_0001);
    rd(AW'(4), v);
    check("R3 plain replace", v, 32'h0000_0001);
    check("R5 active untouched", act(0), 32'h0);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    wr(AW'(NR), 32'h0000_0000);
    check("R6 zero bit no arm", {31'h0, commit_pending}, 32'h0);
    wr(AW'(NR), 32'h0000_0001);
    check("R6 arm pin", {31'h0, commit_pending}, 32'h1);
    rd(AW'(NR), v);
    check("R6 arm readback", v, 32'h1);
    frame();
    check("R7 copy slot0", act(0), 32'h0000_1AC4);
    check("R7 copy slot4", act(4), 32'h0000_0001);
    check("R7 pending clear", {31'h0, commit_pending}, 32'h0);
    wr(AW'(4), 32'h0000_0055);
    frame();
    check("R7 idle frame no copy", act(4), 32'h0000_0001);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    // config-done together with frame, nothing armed
    cyc(1'b1, AW'(NR), 32'h1, 1'b1);
    check("R8 armed after collide", {31'h0, commit_pending}, 32'h1);
    check("R8 no copy when unarmed", act(4), 32'h0000_0001);
    frame();
    check("R8 later copy", act(4), 32'h0000_0055);
    // data write together with a committing frame
    wr(AW'(4), 32'h0000_0066);
    wr(AW'(NR), 32'h1);
    cyc(1'b1, AW'(4), 32'h0000_0077, 1'b1);
    check("R9 active pre-write", act(4), 32'h0000_0066);
    check("R9 pending cleared", {31'h0, commit_pending}, 32'h0);
    rd(AW'(4), v);
    check("R9 shadow new value", v, 32'h0000_0077);
    // config-done together with a committing frame
    wr(AW'(NR), 32'h1);
    cyc(1'b1, AW'(NR), 32'h1, 1'b1);
    check("R8 copy while armed", act(4), 32'h0000_0077);
    check("R8 stays armed", {31'h0, commit_pending}, 32'h1);
    frame();
    check("R8 second frame clears", {31'h0, commit_pending}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(AW'(15), 32'hFFFF_FFFF);
    check("R11 no arm", {31'h0, commit_pending}, 32'h0);
    rd(AW'(15), v);
    check("R11 read zero", v, 32'h0);
    rd(AW'(0), v);
    check("R11 slot0 intact", v, 32'h0000_1AC4);
    rd(AW'(4), v);
    check("R11 slot4 intact", v, 32'h0000_0077);
  endtask

  task automatic t_reset_mid();
    logic [31:0] v;
    do_reset();
    check("R10 mid reset active", act(4), 32'h0);
    rd(AW'(0), v);
    check("R10 mid reset shadow", v, 32'h0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; frame_start = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    t_reset();
    t_masked();
    t_plain();
    t_commit();
    t_collide();
    t_unmapped();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule